// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer for a 10-bit successive-approximation analog-to-digital converter. Software starts a conversion by setting a start/busy control bit. The sequencer waits for the last quarter-phase of the current four-clock instruction cycle, freezes the sample-and-hold, and then produces a converter time base. That time base is either the system clock divided by 2, 8 or 32, or a pulse train from a separate RC oscillator. On each tick of the time base the sequencer steps through one bit trial, starting at the most significant bit. It drives a trial code to the external DAC and reads an external comparator.

A conversion lasts twelve converter periods. Ten of them resolve bits, and two finish the conversion. At the end the sequencer loads the result register, clears the busy bit, releases the sample-and-hold and sets a sticky completion flag. The result register keeps its previous value until that moment. When the RC source is selected, one whole instruction cycle (four clocks) is inserted before the converter ticks are counted. Software can abort a running conversion by clearing the busy bit.

Top module: `sar_seq`

## Requirements
- R1: `q4_o` is high in exactly one clock of every four. A `go_set_i` pulse while idle sets `go_o` at the next edge. `sampling_o` falls only at an edge for which `q4_o` was high in the preceding cycle, and that edge is the first such edge after `go_o` is set.
- R2: With `clk_sel_i` = 0, 1 or 2, the divide ratio D is 2, 8 or 32 respectively. In these modes, `go_o` falls exactly 12*D clocks after the edge at which `sampling_o` fell.
- R3: With `clk_sel_i` = 3 (RC mode), `rc_tick_i` pulses sampled in the first 4 clocks after `sampling_o` falls are ignored. The conversion completes at the edge that samples the 12th counted pulse.
- R4: Bits are resolved from bit 9 down to bit 0. The first trial code on `dac_o` is 0x200. A bit is kept when `cmp_i` is 1 (input at or above the DAC level). With an ideal comparator, the result equals the input code.
- R5: `result_o` keeps its previous value for the whole conversion and changes only at completion. `dac_o` is 0 whenever `sampling_o` is high.
- R6: At completion, in the same edge, `go_o` clears, `flag_o` sets and `sampling_o` returns high.
- R7: A `go_set_i` pulse during a conversion has no effect on the conversion time or on the result.
- R8: A `go_clr_i` pulse during a conversion aborts it. At the next edge `go_o` is 0 and `sampling_o` is 1, `result_o` is unchanged, and `flag_o` stays 0.
- R9: `clk_sel_i` is captured only at the `go_set_i` that starts a conversion. Changing it mid-conversion does not alter the conversion time.
- R10: `flag_o` stays set until a `flag_clr_i` pulse clears it. A completion in the same cycle as `flag_clr_i` leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| go_set_i | input | 1 | Software write strobe setting the start/busy bit |
| go_clr_i | input | 1 | Software write strobe clearing the start/busy bit (abort) |
| clk_sel_i | input | 2 | Converter clock source: 0 = /2, 1 = /8, 2 = /32, 3 = RC |
| rc_tick_i | input | 1 | One-cycle pulse per RC oscillator period, already synchronized |
| cmp_i | input | 1 | Comparator: 1 when the held input is at or above the DAC level |
| flag_clr_i | input | 1 | Software write strobe clearing the completion flag |
| q4_o | output | 1 | High in the last quarter-phase of each instruction cycle |
| go_o | output | 1 | Start/busy bit |
| sampling_o | output | 1 | Sample-and-hold tracking (1) or holding (0) |
| dac_o | output | 10 | Trial code for the DAC |
| result_o | output | 10 | Conversion result register |
| flag_o | output | 1 | Sticky completion interrupt flag |

## Verification
The hardest case to reach from the ports is a software flag clear that lands in exactly the same clock as a completion. The bench reaches it by predicting the completion edge from the 12*D rule, counted from the observed fall of `sampling_o`, and placing the clear strobe in that one cycle while the flag is still set from the previous run. RC-mode timing is covered the same way: a pulse pattern whose pulses fall inside the four-clock guard window, so that counting them would shift the completion edge. A behavioural comparator turns every one of the 1024 input codes into a full bit-trial sequence at the fastest divider.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DLY  = 2'd2,
    ST_CONV = 2'd3
  } sar_state_e;

  localparam logic [1:0] SEL_RC = 2'd3;
endpackage

// File: rtl/sar_phase.sv
module sar_phase #(
  parameter int PHASES = 4
) (
  input  logic clk,
  input  logic rst,
  output logic last_o
);
  localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1;
  logic [PW-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst)                          ph <= '0;
    else if (ph == PW'(PHASES - 1))   ph <= '0;
    else                              ph <= ph + 1'b1;
  end

  assign last_o = (ph == PW'(PHASES - 1));
endmodule

// File: rtl/sar_tadgen.sv
module sar_tadgen #(
  parameter int DIV0 = 2,
  parameter int DIV1 = 8,
  parameter int DIV2 = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  input  logic       rc_tick_i,
  output logic       tick_o
);
  import sar_pkg::*;
  localparam int MAXD01 = (DIV0 > DIV1) ? DIV0 : DIV1;
  localparam int MAXD   = (MAXD01 > DIV2) ? MAXD01 : DIV2;
  localparam int CW     = $clog2(MAXD);

  logic [CW-1:0] cnt, lim;

  always_comb begin
    case (sel_i)
      2'd0:    lim = CW'(DIV0 - 1);
      2'd1:    lim = CW'(DIV1 - 1);
      default: lim = CW'(DIV2 - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !run_i)     cnt <= '0;
    else if (cnt == lim)   cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign tick_o = run_i && ((sel_i == SEL_RC) ? rc_tick_i : (cnt == lim));
endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
  parameter int NBITS = 10,
  parameter int SW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [SW-1:0]    step_i,
  input  logic             cmp_i,
  output logic [NBITS-1:0] trial_o
);
  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      trial_o <= '0;
    end else if (start_i) begin
      trial_o <= NBITS'(1) << (NBITS - 1);
    end else if (tick_i && (int'(step_i) < NBITS)) begin
      for (int i = 0; i < NBITS; i++)
        if ((i == NBITS - 1 - int'(step_i)) && !cmp_i) trial_o[i] <= 1'b0;
      for (int j = 0; j < NBITS - 1; j++)
        if (j == NBITS - 2 - int'(step_i)) trial_o[j] <= 1'b1;
    end
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int NBITS  = 10,
  parameter int TAIL   = 2,
  parameter int PHASES = 4,
  parameter int DIV0   = 2,
  parameter int DIV1   = 8,
  parameter int DIV2   = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_set_i,
  input  logic             go_clr_i,
  input  logic [1:0]       clk_sel_i,
  input  logic             rc_tick_i,
  input  logic             cmp_i,
  input  logic             flag_clr_i,
  output logic             q4_o,
  output logic             go_o,
  output logic             sampling_o,
  output logic [NBITS-1:0] dac_o,
  output logic [NBITS-1:0] result_o,
  output logic             flag_o
);
  import sar_pkg::*;
  localparam int NSTEPS = NBITS + TAIL;
  localparam int SW     = $clog2(NSTEPS);
  localparam int DW     = (PHASES > 1) ? $clog2(PHASES) : 1;

  sar_state_e    state;
  logic [1:0]    sel_q;
  logic [SW-1:0] step;
  logic [DW-1:0] dly;
  logic          tick, start_w, done_w, abort_w;

  sar_phase #(.PHASES(PHASES)) u_phase (
    .clk(clk), .rst(rst), .last_o(q4_o)
  );

  sar_tadgen #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2)) u_tad (
    .clk(clk), .rst(rst), .run_i(state == ST_CONV), .sel_i(sel_q),
    .rc_tick_i(rc_tick_i), .tick_o(tick)
  );

  assign abort_w = go_clr_i && (state != ST_IDLE);
  assign start_w = (state == ST_WAIT) && q4_o && !go_clr_i;
  assign done_w  = (state == ST_CONV) && tick && (step == SW'(NSTEPS - 1)) && !go_clr_i;

  sar_trial #(.NBITS(NBITS), .SW(SW)) u_trial (
    .clk(clk), .rst(rst), .clear_i(abort_w || done_w), .start_i(start_w),
    .tick_i(tick && (state == ST_CONV)), .step_i(step), .cmp_i(cmp_i),
    .trial_o(dac_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      go_o     <= 1'b0;
      sel_q    <= 2'd0;
      step     <= '0;
      dly      <= '0;
      result_o <= '0;
      flag_o   <= 1'b0;
    end else begin
      if (done_w)          flag_o <= 1'b1;
      else if (flag_clr_i) flag_o <= 1'b0;

      if (abort_w) begin
        state <= ST_IDLE;
        go_o  <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: if (go_set_i) begin
            state <= ST_WAIT;
            go_o  <= 1'b1;
            sel_q <= clk_sel_i;
          end
          ST_WAIT: if (q4_o) begin
            state <= (sel_q == SEL_RC) ? ST_DLY : ST_CONV;
            dly   <= '0;
            step  <= '0;
          end
          ST_DLY: begin
            if (dly == DW'(PHASES - 1)) state <= ST_CONV;
            else                        dly   <= dly + 1'b1;
          end
          default: if (tick) begin
            if (step == SW'(NSTEPS - 1)) begin
              state    <= ST_IDLE;
              go_o     <= 1'b0;
              result_o <= dac_o;
            end else begin
              step <= step + 1'b1;
            end
          end
        endcase
      end
    end
  end

  assign sampling_o = (state == ST_IDLE) || (state == ST_WAIT);
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int NBITS = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             q4_o,
  input logic             go_o,
  input logic             sampling_o,
  input logic [NBITS-1:0] dac_o,
  input logic [NBITS-1:0] result_o,
  input logic             flag_o,
  input logic             flag_clr_i,
  input logic             done_w
);
  p_q4_single_r1: assert property (@(posedge clk) disable iff (rst)
    q4_o |=> !q4_o);
  p_hold_aligned_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(sampling_o) |-> $past(q4_o));
  p_result_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(result_o) |-> $fell(go_o));
  p_dac_idle_r5: assert property (@(posedge clk) disable iff (rst)
    sampling_o |-> (dac_o == '0));
  p_complete_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> ($fell(go_o) && $rose(sampling_o)));
  p_busy_while_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !sampling_o |-> go_o);
  p_flag_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (flag_clr_i && !done_w) |=> !flag_o);
  p_flag_wins_r10: assert property (@(posedge clk) disable iff (rst)
    done_w |=> flag_o);
endmodule

bind sar_seq sar_seq_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst(rst), .q4_o(q4_o), .go_o(go_o), .sampling_o(sampling_o),
  .dac_o(dac_o), .result_o(result_o), .flag_o(flag_o),
  .flag_clr_i(flag_clr_i), .done_w(done_w)
);

// File: tb/sar_seq_tb.sv
module sar_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       go_set = 0, go_clr = 0, rc_tick = 0, flag_clr = 0;
  logic [1:0] clk_sel = 0;
  logic [9:0] vin = 0;
  logic       q4, go, sampling, flag, cmp;
  logic [9:0] dac, result;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  assign cmp = (vin >= dac);

  sar_seq u_dut (
    .clk(clk), .rst(rst), .go_set_i(go_set), .go_clr_i(go_clr),
    .clk_sel_i(clk_sel), .rc_tick_i(rc_tick), .cmp_i(cmp),
    .flag_clr_i(flag_clr), .q4_o(q4), .go_o(go), .sampling_o(sampling),
    .dac_o(dac), .result_o(result), .flag_o(flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int div_of(input logic [1:0] s);
    return (s == 2'd0) ? 2 : (s == 2'd1) ? 8 : 32;
  endfunction

  // mode: 0 plain, 1 extra go_set mid-run, 2 clk_sel change mid-run, 3 clear at completion
  task automatic run_conv(input logic [1:0] sel, input logic [9:0] v, input int mode);
    logic [9:0] old;
    logic       pq;
    int n, expn, qual;
    old = result;
    @(negedge clk); vin = v; clk_sel = sel; go_set = 1;
    @(negedge clk); go_set = 0;
    chk(go == 1'b1, "R1 go set", int'(go), 1);
    pq = q4; n = 0;
    while (sampling && n < 20) begin
      @(negedge clk);
      if (!sampling) chk(pq == 1'b1, "R1 start after q4", int'(pq), 1);
      pq = q4; n++;
    end
    chk(dac == 10'h200, "R4 first trial", int'(dac), 512);
    expn = (sel == 2'd3) ? -1 : 12 * div_of(sel) + 1;
    qual = 0; n = 1;
    while (go && n < 3000) begin
      chk(result == old, "R5 result held", int'(result), int'(old));
      chk(sampling == 1'b0, "R7 holding", int'(sampling), 0);
      rc_tick  = (sel == 2'd3) && (n % 3 == 0);
      if (rc_tick && n >= 5) begin
        qual++;
        if (qual == 12) expn = n + 1;
      end
      go_set   = (mode == 1) && (n == 10);
      if (mode == 2 && n == 5) clk_sel = (sel == 2'd0) ? 2'd2 : 2'd0;
      flag_clr = (mode == 3) && (n == expn - 1);
      @(negedge clk); n++;
    end
    rc_tick = 0; go_set = 0; flag_clr = 0; clk_sel = sel;
    if (sel == 2'd3) chk(n == expn, "R3 RC completion edge", n, expn);
    else             chk(n == expn, "R2 divided completion edge", n, expn);
    chk(result == v, "R4 result code", int'(result), int'(v));
    chk(flag == 1'b1, "R6 flag set", int'(flag), 1);
    chk(sampling == 1'b1, "R6 sampling resumed", int'(sampling), 1);
    chk(dac == 10'd0, "R5 dac idle", int'(dac), 0);
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
    chk(flag == 1'b0, "R10 flag cleared", int'(flag), 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [9:0] keep;
    int q4cnt;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(go == 0 && sampling == 1 && flag == 0 && result == 0 && dac == 0,
        "R1 reset state", int'({go, sampling, flag}), 3'b010);
    q4cnt = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); if (q4) q4cnt++;
    end
    chk(q4cnt == 4, "R1 q4 one in four", q4cnt, 4);

    // full code sweep at the fastest divider
    for (int c = 0; c < 1024; c++) begin
      run_conv(2'd0, 10'(c), 0);
      clear_flag();
    end
    for (int c = 0; c < 16; c++) begin
      run_conv(2'd1, 10'(c * 67 + 3), 0);
      clear_flag();
    end
    for (int c = 0; c < 6; c++) begin
      run_conv(2'd2, 10'(c * 200 + 11), 0);
      clear_flag();
    end
    for (int c = 0; c < 12; c++) begin
      run_conv(2'd3, 10'(c * 93 + 1), 0);
      clear_flag();
    end
    run_conv(2'd3, 10'h3ff, 0); clear_flag();
    run_conv(2'd3, 10'h000, 0); clear_flag();

    // R7: extra start write during a run
    run_conv(2'd1, 10'd600, 1); clear_flag();
    run_conv(2'd3, 10'd77, 1);  clear_flag();
    // R9: select change mid-run
    run_conv(2'd0, 10'd345, 2); clear_flag();
    run_conv(2'd2, 10'd900, 2); clear_flag();
    // R10: flag already set, clear arrives in the completion cycle
    run_conv(2'd0, 10'd5, 0);
    run_conv(2'd0, 10'd700, 3);
    chk(flag == 1'b1, "R10 completion wins over clear", int'(flag), 1);
    @(negedge clk);
    chk(flag == 1'b1, "R10 flag sticky", int'(flag), 1);
    clear_flag();

    // R8: abort mid-conversion
    keep = result;
    @(negedge clk); vin = 10'd123; clk_sel = 2'd1; go_set = 1;
    @(negedge clk); go_set = 0;
    while (sampling) @(negedge clk);
    repeat (20) @(negedge clk);
    go_clr = 1;
    @(negedge clk); go_clr = 0;
    chk(go == 1'b0, "R8 abort clears go", int'(go), 0);
    chk(sampling == 1'b1, "R8 abort resumes sampling", int'(sampling), 1);
    repeat (150) @(negedge clk);
    chk(flag == 1'b0, "R8 no flag after abort", int'(flag), 0);
    chk(result == keep, "R8 result unchanged", int'(result), int'(keep));
    chk(dac == 10'd0, "R8 dac cleared", int'(dac), 0);
    run_conv(2'd0, 10'd321, 0); clear_flag();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule